// File: doc/BRIEF.md
# Input amplitude AGC and format selector

This block sits on the input side of a time-code receiver and runs at the audio sample rate. Each accepted input sample carries two energy terms, one from each of two candidate signal filters. The block sums those terms separately over one second of samples and then chooses the stronger format, along with the decimation factor that the rest of the receiver must use for it. In the same per-second step it moves an 8-bit codec gain register up or down by a fixed step, so that the per-baud peak estimate reported by the demodulator stays inside a target window.

The block also tracks the absolute amplitude of the incoming samples. The tracker follows a rising input at once and falls back slowly. A low-signal flag marks any baud whose peak estimate is too small to demodulate. The filters, the demodulator and the codec register interface are outside this block. It receives their results and returns a gain value that comes with a one-cycle update strobe.

Top module: `amp_fmt_ctl`

## Requirements
- R1: After reset, `gain` is 127, `fmt_sel` is 0, `decim` is 1, `pk_amp` is 0, and both `gain_upd` and `low_sig` are 0.
- R2: Only cycles with `smp_vld` high count as samples. The SEC_LEN-th counted sample since reset, and every SEC_LEN-th one after it, is a second boundary. In the cycle after each boundary `gain_upd` is high for exactly one cycle, and it is low at all other times.
- R3: At a boundary, the second's sum of `eng_a` is compared with its sum of `eng_b`. Both sums include the boundary sample. If the `eng_a` sum is strictly larger, `fmt_sel` becomes 0 and `decim` becomes 1 in the next cycle.
- R4: At a boundary where the `eng_a` sum is less than or equal to the `eng_b` sum, `fmt_sel` becomes 1 and `decim` becomes 10. A tie therefore selects format 1.
- R5: Both energy sums restart from zero after every boundary. A second's decision depends only on that second's samples.
- R6: At a boundary where the effective baud peak is below 2000, `gain` rises by 4 and saturates at 255. The effective baud peak is `baud_pk` if `baud_vld` is high in the boundary cycle, and otherwise the last `baud_pk` taken with `baud_vld` (0 after reset).
- R7: At a boundary where the effective baud peak is above 3000, `gain` falls by 4 and saturates at 0. For peaks from 2000 to 3000 inclusive, and in all cycles that are not boundaries, `gain` holds its value.
- R8: When a sample's absolute value is larger than `pk_amp`, `pk_amp` equals that absolute value in the next cycle. The sample -32768 gives 32768.
- R9: Otherwise, the internal peak P, which holds 10 fraction bits, becomes P - ((P - A) >> 10), where A is the absolute sample scaled by 1024. `pk_amp` is P >> 10.
- R10: A `baud_vld` cycle with `baud_pk` below 100 sets `low_sig` from the next cycle. The flag stays set until the next boundary. At the boundary it reloads with only that cycle's own low-baud condition.
- R11: While `smp_vld` is low, `smp`, `eng_a` and `eng_b` have no effect on `pk_amp`, on the sums or on the second count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp | input | 16 | Signed decompanded sample |
| eng_a | input | 16 | Energy term, format 0 filter |
| eng_b | input | 16 | Energy term, format 1 filter |
| baud_vld | input | 1 | Baud peak strobe |
| baud_pk | input | 17 | Per-baud peak estimate |
| gain | output | 8 | Codec gain register |
| gain_upd | output | 1 | One-cycle strobe after each gain decision |
| fmt_sel | output | 1 | Selected format (0 or 1) |
| decim | output | 4 | Decimation factor for selected format |
| low_sig | output | 1 | Low-signal flag |
| pk_amp | output | 17 | Tracked peak amplitude, integer part |

## Verification
Two situations are hard to reach from the ports. The first is the gain running into either rail, which takes dozens of consecutive boundaries with the peak held outside the window. The bench shortens the second to 50 samples, so it can drive the gain from 127 up to 255 and then down to 0 within a few thousand cycles. The second is proving that the sums are cleared. A second with an overwhelming format 1 energy is followed by one where format 0 wins by a single unit, and gapped idle cycles carrying large junk values are mixed in to show that only strobed samples count.

// File: rtl/afs_pkg.sv
package afs_pkg;
    typedef enum logic {
        FMT_A = 1'b0,
        FMT_B = 1'b1
    } fmt_e;

    typedef logic [7:0] gain_t;
endpackage

// File: rtl/afs_peak_trk.sv
module afs_peak_trk #(
    parameter int SW   = 16,
    parameter int FRAC = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [SW-1:0] smp,
    output logic [SW:0]   pk_amp
);
    localparam int FW = SW + 1 + FRAC;

    typedef struct packed {
        logic [FW-1:0] pk;
    } st_t;

    st_t st_d, st_q;
    logic signed [SW:0] sx;
    logic [SW:0]        mag;
    logic [FW-1:0]      mag_fx;
    logic [FW-1:0]      diff;

    always_comb begin
        st_d   = st_q;
        sx     = {smp[SW-1], smp};
        mag    = (sx < 0) ? SW'(0) - sx : sx;
        mag    = sx[SW] ? (SW+1)'(-sx) : (SW+1)'(sx);
        mag_fx = {mag, {FRAC{1'b0}}};
        diff   = st_q.pk - mag_fx;
        if (smp_vld) begin
            if (mag_fx > st_q.pk) begin
                st_d.pk = mag_fx;
            end else begin
                st_d.pk = st_q.pk - (diff >> FRAC);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pk_amp = st_q.pk[FW-1:FRAC];

    p_attack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && mag > pk_amp) |=> (pk_amp == $past(mag)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(pk_amp));

    p_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && mag <= pk_amp) |=> (pk_amp <= $past(pk_amp)));
endmodule

// File: rtl/afs_energy_sel.sv
module afs_energy_sel
    import afs_pkg::*;
#(
    parameter int SEC_LEN = 8000,
    parameter int EW      = 16,
    parameter int DW      = 4,
    parameter int DECIM_A = 1,
    parameter int DECIM_B = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [EW-1:0] eng_a,
    input  logic [EW-1:0] eng_b,
    output logic          sec_tick,
    output fmt_e          fmt,
    output logic [DW-1:0] decim
);
    localparam int CW = $clog2(SEC_LEN);
    localparam int AW = EW + CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc_a;
        logic [AW-1:0] acc_b;
        fmt_e          fmt;
        logic [DW-1:0] decim;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] sum_a, sum_b;

    always_comb begin
        st_d     = st_q;
        sum_a    = st_q.acc_a + AW'(eng_a);
        sum_b    = st_q.acc_b + AW'(eng_b);
        sec_tick = smp_vld && (st_q.cnt == CW'(SEC_LEN - 1));
        if (smp_vld) begin
            if (sec_tick) begin
                st_d.cnt   = '0;
                st_d.acc_a = '0;
                st_d.acc_b = '0;
                if (sum_a > sum_b) begin
                    st_d.fmt   = FMT_A;
                    st_d.decim = DW'(DECIM_A);
                end else begin
                    st_d.fmt   = FMT_B;
                    st_d.decim = DW'(DECIM_B);
                end
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.acc_a = sum_a;
                st_d.acc_b = sum_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.acc_a <= '0;
            st_q.acc_b <= '0;
            st_q.fmt   <= FMT_A;
            st_q.decim <= DW'(DECIM_A);
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt   = st_q.fmt;
    assign decim = st_q.decim;

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(SEC_LEN));

    p_fmt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> ($stable(fmt) && $stable(decim)));

    p_decim_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == FMT_B) |-> (decim == DW'(DECIM_B)));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (st_q.acc_a == '0 && st_q.acc_b == '0));
endmodule

// File: rtl/afs_gain_ctl.sv
module afs_gain_ctl
    import afs_pkg::*;
#(
    parameter int PW      = 17,
    parameter int LO_TH   = 2000,
    parameter int HI_TH   = 3000,
    parameter int DROP_TH = 100,
    parameter int STEP    = 4,
    parameter int G_INIT  = 127,
    parameter int G_MAX   = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          baud_vld,
    input  logic [PW-1:0] baud_pk,
    output gain_t         gain,
    output logic          gain_upd,
    output logic          low_sig
);
    typedef struct packed {
        gain_t         gain;
        logic          upd;
        logic          low;
        logic [PW-1:0] bpk;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] pk_eff;
    logic [8:0]    g_up;
    logic          low_now;

    always_comb begin
        st_d     = st_q;
        pk_eff   = baud_vld ? baud_pk : st_q.bpk;
        g_up     = {1'b0, st_q.gain} + 9'(STEP);
        low_now  = baud_vld && (baud_pk < PW'(DROP_TH));
        st_d.upd = sec_tick;
        if (baud_vld) begin
            st_d.bpk = baud_pk;
        end
        if (sec_tick) begin
            st_d.low = low_now;
            if (pk_eff < PW'(LO_TH)) begin
                st_d.gain = (g_up > 9'(G_MAX)) ? gain_t'(G_MAX) : g_up[7:0];
            end else if (pk_eff > PW'(HI_TH)) begin
                st_d.gain = (st_q.gain < gain_t'(STEP)) ? '0 : st_q.gain - gain_t'(STEP);
            end
        end else begin
            st_d.low = st_q.low | low_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.gain <= gain_t'(G_INIT);
            st_q.upd  <= 1'b0;
            st_q.low  <= 1'b0;
            st_q.bpk  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain     = st_q.gain;
    assign gain_upd = st_q.upd;
    assign low_sig  = st_q.low;

    p_gain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(gain));

    p_window_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && pk_eff >= PW'(LO_TH) && pk_eff <= PW'(HI_TH)) |=> $stable(gain));

    p_gain_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && pk_eff < PW'(LO_TH)) |=> (gain >= $past(gain)));

    p_upd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> gain_upd);

    p_low_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_vld && baud_pk < PW'(DROP_TH)) |=> low_sig);
endmodule

// File: rtl/amp_fmt_ctl.sv
module amp_fmt_ctl
    import afs_pkg::*;
#(
    parameter int SEC_LEN = 8000,
    parameter int SW      = 16,
    parameter int EW      = 16,
    parameter int DW      = 4,
    parameter int FRAC    = 10,
    parameter int DECIM_A = 1,
    parameter int DECIM_B = 10,
    parameter int LO_TH   = 2000,
    parameter int HI_TH   = 3000,
    parameter int DROP_TH = 100,
    parameter int STEP    = 4,
    parameter int G_INIT  = 127,
    parameter int G_MAX   = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [SW-1:0] smp,
    input  logic [EW-1:0] eng_a,
    input  logic [EW-1:0] eng_b,
    input  logic          baud_vld,
    input  logic [SW:0]   baud_pk,
    output logic [7:0]    gain,
    output logic          gain_upd,
    output logic          fmt_sel,
    output logic [DW-1:0] decim,
    output logic          low_sig,
    output logic [SW:0]   pk_amp
);
    logic  sec_tick;
    fmt_e  fmt;
    gain_t gain_w;

    afs_peak_trk #(
        .SW   (SW),
        .FRAC (FRAC)
    ) u_peak (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp     (smp),
        .pk_amp  (pk_amp)
    );

    afs_energy_sel #(
        .SEC_LEN (SEC_LEN),
        .EW      (EW),
        .DW      (DW),
        .DECIM_A (DECIM_A),
        .DECIM_B (DECIM_B)
    ) u_energy (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .eng_a    (eng_a),
        .eng_b    (eng_b),
        .sec_tick (sec_tick),
        .fmt      (fmt),
        .decim    (decim)
    );

    afs_gain_ctl #(
        .PW      (SW + 1),
        .LO_TH   (LO_TH),
        .HI_TH   (HI_TH),
        .DROP_TH (DROP_TH),
        .STEP    (STEP),
        .G_INIT  (G_INIT),
        .G_MAX   (G_MAX)
    ) u_gain (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .baud_vld (baud_vld),
        .baud_pk  (baud_pk),
        .gain     (gain_w),
        .gain_upd (gain_upd),
        .low_sig  (low_sig)
    );

    assign gain    = gain_w;
    assign fmt_sel = fmt;

    p_upd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gain_upd |=> !gain_upd);

    p_fmt_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel != $past(fmt_sel)) |-> gain_upd);
endmodule

// File: tb/sim_amp_fmt_ctl.sv
module sim_amp_fmt_ctl;
    localparam int SEC = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp = '0;
    logic [15:0] eng_a = '0;
    logic [15:0] eng_b = '0;
    logic        baud_vld = 1'b0;
    logic [16:0] baud_pk = '0;
    logic [7:0]  gain;
    logic        gain_upd;
    logic        fmt_sel;
    logic [3:0]  decim;
    logic        low_sig;
    logic [16:0] pk_amp;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int    m_cnt, m_gain, m_fmt, m_decim, m_upd, m_low, m_bpk;
    longint m_acc_a, m_acc_b, m_pk;

    always #2.5 clk = ~clk;

    amp_fmt_ctl #(.SEC_LEN(SEC)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
        .eng_a(eng_a), .eng_b(eng_b), .baud_vld(baud_vld), .baud_pk(baud_pk),
        .gain(gain), .gain_upd(gain_upd), .fmt_sel(fmt_sel), .decim(decim),
        .low_sig(low_sig), .pk_amp(pk_amp)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_gain = 127; m_fmt = 0; m_decim = 1; m_upd = 0;
        m_low = 0; m_bpk = 0; m_acc_a = 0; m_acc_b = 0; m_pk = 0;
    endtask

    task automatic compare_all();
        check("R6 R7 gain", gain, m_gain);
        check("R2 gain_upd", gain_upd, m_upd);
        check("R3 R4 fmt_sel", fmt_sel, m_fmt);
        check("R3 R4 decim", decim, m_decim);
        check("R10 low_sig", low_sig, m_low);
        check("R8 R9 pk_amp", pk_amp, m_pk >> 10);
    endtask

    // one clock: check state, apply inputs, advance model
    task automatic cyc(input bit v, input int s, input int ea, input int eb,
                       input bit bv, input int bp);
        longint a, sa, sb;
        int pe;
        bit tick, lown;
        @(negedge clk);
        compare_all();
        smp_vld = v; smp = s[15:0]; eng_a = ea[15:0]; eng_b = eb[15:0];
        baud_vld = bv; baud_pk = bp[16:0];
        tick = 0;
        if (v) begin
            a = (s < 0) ? -s : s;
            a = a * 1024;
            if (a > m_pk) m_pk = a;
            else m_pk = m_pk - ((m_pk - a) >> 10);
            sa = m_acc_a + ea; sb = m_acc_b + eb;
            if (m_cnt == SEC - 1) begin
                tick = 1; m_cnt = 0; m_acc_a = 0; m_acc_b = 0;
                if (sa > sb) begin m_fmt = 0; m_decim = 1; end
                else begin m_fmt = 1; m_decim = 10; end
            end else begin
                m_cnt++; m_acc_a = sa; m_acc_b = sb;
            end
        end
        pe = bv ? bp : m_bpk;
        if (bv) m_bpk = bp;
        lown = bv && (bp < 100);
        if (tick) begin
            m_low = lown;
            if (pe < 2000) m_gain = (m_gain + 4 > 255) ? 255 : m_gain + 4;
            else if (pe > 3000) m_gain = (m_gain < 4) ? 0 : m_gain - 4;
        end else begin
            m_low = m_low | lown;
        end
        m_upd = tick;
    endtask

    // one second of strobed samples, with optional idle junk cycles (R11)
    task automatic run_sec(input int ea, input int eb, input int bp, input bit gaps);
        for (int i = 0; i < SEC; i++) begin
            if (gaps && (i % 3 == 0))
                cyc(1'b0, -30000, 65535, 65535, 1'b0, 0);
            cyc(1'b1, ((i * 7919) % 4000) - 2000, ea, eb, (i % 10 == 9), bp);
        end
    endtask

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 gain", gain, 127);
        check("R1 fmt_sel", fmt_sel, 0);
        check("R1 decim", decim, 1);
        check("R1 pk_amp", pk_amp, 0);
        check("R1 flags", {gain_upd, low_sig}, 0);

        // R3: format 0 stronger, peak low -> gain up (R6)
        run_sec(100, 50, 1500, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R3 chose format 0", fmt_sel, 0);
        check("R6 gain after rise", gain, 131);

        // R4: format 1 stronger, peak high -> gain down (R7)
        run_sec(10, 20, 3500, 1'b1);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R4 chose format 1", fmt_sel, 1);
        check("R4 decim 10", decim, 10);
        check("R7 gain after fall", gain, 127);

        // R4 tie -> format 1; R7 window edges hold
        run_sec(0, 0, 2000, 1'b0);
        run_sec(7, 7, 3000, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R4 tie picks format 1", fmt_sel, 1);
        check("R7 window hold", gain, 127);

        // R5: huge format 1 second then format 0 wins by one unit
        run_sec(0, 60000, 2500, 1'b0);
        for (int i = 0; i < SEC; i++)
            cyc(1'b1, 5, 100, (i == 0) ? 99 : 100, 1'b0, 0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R5 sums cleared, format 0", fmt_sel, 0);

        // R11: idle junk does not move the second count
        run_sec(100, 200, 2500, 1'b1);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R11 idle ignored, format 1", fmt_sel, 1);

        // R8: attack to full scale including -32768, then R9 decay
        cyc(1'b1, -32768, 0, 0, 1'b0, 0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R8 attack -32768", pk_amp, 32768);
        for (int i = 0; i < 300; i++) cyc(1'b1, 0, 0, 0, 1'b0, 0);
        check("R9 decayed below full", pk_amp < 32768, 1);

        // R10: low baud sets flag; 100 does not
        cyc(1'b0, 0, 0, 0, 1'b1, 100);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R10 peak 100 no flag", low_sig, m_low);
        cyc(1'b0, 0, 0, 0, 1'b1, 99);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R10 peak 99 sets flag", low_sig, 1);

        // R6: saturate at 255
        for (int k = 0; k < 36; k++) run_sec(1, 2, 500, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R6 gain saturates 255", gain, 255);

        // R7: saturate at 0
        for (int k = 0; k < 68; k++) run_sec(2, 1, 9000, 1'b0);
        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        check("R7 gain saturates 0", gain, 0);

        cyc(1'b0, 0, 0, 0, 1'b0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule